// File: doc/BRIEF.md
# Polled Character Port

This block connects a single keystroke source and a single character display to a processor bus. It has three registers at fixed word offsets above a base address set by a parameter. Software polls the status register. When the input-ready flag is set, software reads the captured key code. When the output-ready flag is set, software writes the next character to show.

Each flag clears as a side effect of the bus access that uses it. Reading the key register drops the input-ready flag. Writing the display register drops the output-ready flag and presents the character to the display. The display reports that it has taken the character with a one-cycle done pulse, and the output-ready flag comes back one clock later. After reset the input flag is 0 and the output flag is 1, so a fresh system has nothing to read and room to write.

Read data is combinational. The register is selected by the address in the same cycle as the read strobe. Read side effects take hold at the clock edge that ends that cycle.

Top module: `chario_port`

## Requirements
- R1: After reset the input-ready flag is 0, the output-ready flag is 1, the overrun flag is 0 and `disp_valid` is 0. A status read therefore returns 8'h02.
- R2: A cycle with `key_strobe` high loads `key_code` into the key register and sets the input-ready flag.
- R3: A read at offset 0 returns the key register contents. At the end of that cycle it clears the input-ready flag.
- R4: A write at offset 1 stores `bus_wdata` as the display character and clears the output-ready flag. While the output-ready flag is 0, `disp_valid` is 1 and `disp_code` shows the latest written character. A later write replaces the character.
- R5: If `disp_done` is sampled high at clock edge N while a character is pending, the output-ready flag reads 1 after edge N+1 and not before. A `disp_done` pulse while nothing is pending has no effect.
- R6: A read at offset 2 returns status with bit 0 = input-ready, bit 1 = output-ready, bit 2 = overrun and bits 7:3 = 0. The read leaves both ready flags unchanged.
- R7: A key strobe while the input-ready flag is already 1, with no key read in the same cycle, overwrites the key register and sets the sticky overrun flag. The overrun flag clears at the end of a status read.
- R8: An access whose address lies outside the block's four-word window, or at offset 3, returns 0 on reads and changes no register or flag.
- R9: When a key read and a key strobe happen in the same cycle, the read returns the old code, the new code is kept, input-ready stays 1 and overrun does not change.
- R10: `bus_rdata` is 0 in every cycle without a read at a mapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| key_strobe | input | 1 | New key code present this cycle |
| key_code | input | 8 | Key code from the input device |
| disp_valid | output | 1 | A character is pending for the display |
| disp_code | output | 8 | Pending display character |
| disp_done | input | 1 | Display has taken the pending character |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together. They also assume that `disp_done` is only meaningful while `disp_valid` is high, and that key strobes come as single-cycle pulses. The stimulus drives every bus access as a single one-cycle operation with exactly one strobe. It raises `disp_done` for one cycle only, and it places same-cycle key strobes and key reads only where R9 calls for them. It also sends a stray done pulse on purpose to exercise the ignore rule in R5.

// File: rtl/chario_pkg.sv
package chario_pkg;

    localparam int CHAR_W    = 8;
    localparam int OFS_W     = 2;
    localparam int STAT_BITS = 3;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [OFS_W-1:0] {
        REG_KEY  = 2'd0,
        REG_SHOW = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // packed: first member is the most significant bit
    typedef struct packed {
        logic ovr;
        logic out_rdy;
        logic in_full;
    } stat_t;

    function automatic char_t pack_status(stat_t s);
        return {{(CHAR_W-STAT_BITS){1'b0}}, s};
    endfunction

endpackage

// File: rtl/chario_decode.sv
module chario_decode
    import chario_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit,
    output reg_sel_e          sel,
    output logic              key_rd,
    output logic              show_wr,
    output logic              stat_rd
);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] tag;
    logic             win;

    always_comb begin
        tag     = addr[ADDR_W-1:OFS_W];
        win     = (tag == BASE[ADDR_W-1:OFS_W]);
        sel     = reg_sel_e'(addr[OFS_W-1:0]);
        hit     = win && (sel != REG_NONE);
        key_rd  = hit && rd && (sel == REG_KEY);
        show_wr = hit && wr && (sel == REG_SHOW);
        stat_rd = hit && rd && (sel == REG_STAT);
    end
endmodule

// File: rtl/chario_rx.sv
module chario_rx
    import chario_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  char_t code,
    input  logic  key_rd,
    input  logic  stat_rd,
    output char_t key_buf,
    output logic  in_full,
    output logic  ovr
);
    logic ovr_set;

    always_comb ovr_set = strobe && in_full && !key_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_buf <= '0;
            in_full <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (strobe) begin
                key_buf <= code;
                in_full <= 1'b1;
            end else if (key_rd) begin
                in_full <= 1'b0;
            end
            ovr <= ovr_set || (ovr && !stat_rd);
        end
    end
endmodule

// File: rtl/chario_tx.sv
module chario_tx
    import chario_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  show_wr,
    input  char_t wdata,
    input  logic  done,
    output char_t show_buf,
    output logic  out_rdy
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            show_buf <= '0;
            out_rdy  <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= done && !out_rdy && !show_wr;
            if (show_wr) begin
                show_buf <= wdata;
                out_rdy  <= 1'b0;
            end else if (done_q) begin
                out_rdy <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chario_port.sv
module chario_port
    import chario_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              key_strobe,
    input  logic [7:0]        key_code,
    output logic              disp_valid,
    output logic [7:0]        disp_code,
    input  logic              disp_done
);
    logic     hit, key_rd, show_wr, stat_rd;
    reg_sel_e sel;
    char_t    key_buf, show_buf;
    logic     in_full, out_rdy, ovr;
    stat_t    stat;

    chario_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .hit(hit), .sel(sel),
        .key_rd(key_rd), .show_wr(show_wr), .stat_rd(stat_rd)
    );

    chario_rx u_rx (
        .clk(clk), .rst(rst), .strobe(key_strobe), .code(key_code),
        .key_rd(key_rd), .stat_rd(stat_rd), .key_buf(key_buf),
        .in_full(in_full), .ovr(ovr)
    );

    chario_tx u_tx (
        .clk(clk), .rst(rst), .show_wr(show_wr), .wdata(bus_wdata),
        .done(disp_done), .show_buf(show_buf), .out_rdy(out_rdy)
    );

    always_comb begin
        stat = '{ovr: ovr, out_rdy: out_rdy, in_full: in_full};
        bus_rdata = '0;
        if (bus_rd && hit) begin
            unique case (sel)
                REG_KEY:  bus_rdata = key_buf;
                REG_SHOW: bus_rdata = show_buf;
                REG_STAT: bus_rdata = pack_status(stat);
                default:  bus_rdata = '0;
            endcase
        end
        disp_valid = !out_rdy;
        disp_code  = show_buf;
    end
endmodule

// File: rtl/chario_port_chk.sv
module chario_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       key_strobe,
    input logic [7:0] key_code,
    input logic       disp_valid,
    input logic [7:0] disp_code,
    input logic       disp_done,
    input logic       hit,
    input logic       key_rd,
    input logic       show_wr,
    input logic       stat_rd,
    input logic [7:0] key_buf,
    input logic       in_full,
    input logic       out_rdy,
    input logic       ovr
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!in_full && out_rdy && !ovr && !disp_valid));

    a_r2_key_loads: assert property (@(posedge clk) disable iff (rst)
        key_strobe |=> (in_full && key_buf == $past(key_code)));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (key_rd && !key_strobe) |=> !in_full);

    a_r4_write_pends: assert property (@(posedge clk) disable iff (rst)
        show_wr |=> (!out_rdy && disp_valid && disp_code == $past(bus_wdata)));

    a_r5_done_sets: assert property (@(posedge clk) disable iff (rst)
        $rose(out_rdy) |-> $past(disp_done, 2));

    a_r6_stat_keeps_in: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !key_strobe) |=> (in_full == $past(in_full)));

    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && in_full && !key_rd) |=> ovr);

    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !hit) |-> (bus_rdata == 8'h00));

    a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (key_rd && key_strobe) |=> (in_full && ovr == $past(ovr)));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind chario_port chario_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .key_strobe(key_strobe), .key_code(key_code),
    .disp_valid(disp_valid), .disp_code(disp_code), .disp_done(disp_done),
    .hit(hit), .key_rd(key_rd), .show_wr(show_wr), .stat_rd(stat_rd),
    .key_buf(key_buf), .in_full(in_full), .out_rdy(out_rdy), .ovr(ovr)
);

// File: tb/tb_chario_port.sv
`timescale 1ns/1ps
module tb_chario_port;
    localparam logic [15:0] BASE = 16'h0040;
    localparam logic [15:0] MISS = 16'h0080;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr, key_strobe, disp_done, disp_valid;
    logic [7:0]  bus_wdata, bus_rdata, key_code, disp_code;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [7:0] q_data[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    chario_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_strobe(key_strobe), .key_code(key_code),
        .disp_valid(disp_valid), .disp_code(disp_code), .disp_done(disp_done)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drv(logic rd, logic wr, logic [15:0] a, logic [7:0] wd,
                       logic stb, logic [7:0] kc, logic dn);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        key_strobe = stb; key_code = kc; disp_done = dn;
    endtask

    task automatic idle();
        drv(0, 0, 16'h0, 8'h0, 0, 8'h0, 0);
    endtask

    task automatic settle();
        idle();
        #4;
    endtask

    task automatic rd_at(logic [15:0] a, logic [7:0] exp, string tag,
                         logic stb = 0, logic [7:0] kc = 8'h0);
        q_data.push_back(exp);
        q_tag.push_back(tag);
        drv(1, 0, a, 8'h0, stb, kc, 0);
    endtask

    task automatic wr_at(logic [15:0] a, logic [7:0] d);
        drv(0, 1, a, d, 0, 8'h0, 0);
    endtask

    task automatic key(logic [7:0] c);
        drv(0, 0, 16'h0, 8'h0, 1, c, 0);
    endtask

    task automatic done_pulse();
        drv(0, 0, 16'h0, 8'h0, 0, 8'h0, 1);
    endtask

    // scoreboard monitor: compare read data just before the closing edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (bus_rd === 1'b1 && !rst) begin
                if (q_data.size() == 0) begin
                    chk("scoreboard underflow", 8'h00, 8'hFF);
                end else begin
                    chk(q_tag.pop_front(), bus_rdata, q_data.pop_front());
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #20000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        key_strobe = 0; key_code = 0; disp_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        settle();
        chk("R1 disp_valid", {7'b0, disp_valid}, 8'h00);
        rd_at(BASE + 2, 8'h02, "R1 status after reset");

        // R2 key capture, R6 status read keeps flags
        key(8'h41);
        rd_at(BASE + 2, 8'h03, "R2 in flag set");
        rd_at(BASE + 2, 8'h03, "R6 status read no side effect");

        // R3 key read clears
        rd_at(BASE + 0, 8'h41, "R3 key data");
        rd_at(BASE + 2, 8'h02, "R3 in flag cleared");

        // R4 write clears output flag
        wr_at(BASE + 1, 8'h5A);
        settle();
        chk("R4 disp_valid", {7'b0, disp_valid}, 8'h01);
        chk("R4 disp_code", disp_code, 8'h5A);
        rd_at(BASE + 2, 8'h00, "R4 out flag cleared");

        // R5 done timing
        done_pulse();
        rd_at(BASE + 2, 8'h00, "R5 not yet ready");
        rd_at(BASE + 2, 8'h02, "R5 ready one cycle later");
        done_pulse();
        settle();
        chk("R5 stray done disp_valid", {7'b0, disp_valid}, 8'h00);
        rd_at(BASE + 2, 8'h02, "R5 stray done no effect");

        // R7 overrun
        key(8'h61);
        key(8'h62);
        rd_at(BASE + 2, 8'h07, "R7 overrun set");
        rd_at(BASE + 2, 8'h03, "R7 overrun cleared by status read");
        rd_at(BASE + 0, 8'h62, "R7 newest code kept");

        // R9 same-cycle key read and strobe
        key(8'h63);
        rd_at(BASE + 0, 8'h63, "R9 old code returned", 1, 8'h64);
        rd_at(BASE + 2, 8'h03, "R9 flag kept no overrun");
        rd_at(BASE + 0, 8'h64, "R9 new code kept");

        // R8 address misses
        key(8'h65);
        rd_at(MISS + 0, 8'h00, "R8 miss read zero");
        wr_at(MISS + 1, 8'hAA);
        rd_at(BASE + 3, 8'h00, "R8 offset 3 read zero");
        wr_at(BASE + 3, 8'hBB);
        rd_at(BASE + 2, 8'h03, "R8 flags untouched");
        settle();
        chk("R8 disp_valid untouched", {7'b0, disp_valid}, 8'h00);
        chk("R10 idle rdata", bus_rdata, 8'h00);
        rd_at(BASE + 0, 8'h65, "R8 key data untouched");

        // R4 overwrite while pending, R10 rdata during write
        wr_at(BASE + 1, 8'h58);
        #4;
        chk("R10 rdata during write", bus_rdata, 8'h00);
        wr_at(BASE + 1, 8'h59);
        settle();
        chk("R4 replaced code", disp_code, 8'h59);
        rd_at(BASE + 1, 8'h59, "R4 readback display reg");
        done_pulse();
        idle();
        rd_at(BASE + 2, 8'h02, "R5 ready after second char");

        repeat (3) idle();
        chk("scoreboard drained", 8'(q_data.size()), 8'h00);
        summary();
    end
endmodule